// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Update

This block is the arithmetic and logic stage of a small 8-bit processor core. It covers three groups of operations: add and subtract, bitwise logic, and shift, rotate and nibble swap. Each cycle it takes an operation code, two byte operands and the current flag byte. The caller places an immediate on the second operand when needed. The block then produces the result byte and a write-enable for the destination register.

The updated flag byte is registered. It loads only in a cycle where `issue` is high. Each operation code carries its own mask of flags that it may change. Every flag outside that mask is copied from `flg_in` unchanged.

The caller builds some operations from others:
- A test is AND with the operand given twice.
- A clear is XOR with the operand given twice.
- Immediate forms use the same codes as the register forms.

The flag byte layout, from bit 7 down to bit 0, is:

| Bit | Flag | Meaning |
|-----|------|---------|
| 7 | I | interrupt enable |
| 6 | T | transfer bit |
| 5 | H | half carry |
| 4 | S | sign |
| 3 | V | overflow |
| 2 | N | negative |
| 1 | Z | zero |
| 0 | C | carry |

Top module: `byte_alu`

## Requirements
- R1: ADD (code 0) gives a+b, and ADC (code 1) gives a+b+C. Both update C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (bit 7 of the result), Z (result is zero) and S.
- R2: SUB (code 2) gives a-b, and SBC (code 3) gives a-b-C. C is set on a borrow out of bit 7, H on a borrow out of bit 3, V on signed overflow. N, Z and S are updated too.
- R3: For SBC (code 3) and CPC (code 19), Z ends set only if the result is zero and Z was already set in `flg_in`.
- R4: CP (code 18) and CPC (code 19) set the flags exactly as SUB and SBC do, and keep `res_we` low.
- R5: AND (4), OR (5), XOR (6), INC (9) and DEC (10) change only Z, N, V and S, and keep C and H. V is 0 for the three logic operations. For INC, V is 1 when the result is 0x80. For DEC, V is 1 when the result is 0x7F.
- R6: COM (code 7) gives 0xFF-a, sets C=1 and V=0, and keeps H. NEG (code 8) gives 0x00-a, sets C when the result is nonzero, sets V when the result is 0x80, and sets H on a borrow out of bit 3.
- R7: LSL (code 11) shifts left with 0 into bit 0. ROL (code 13) shifts left with the old C into bit 0. Both put the old bit 7 in C and the old bit 3 in H, and set V = N xor C.
- R8: LSR (12) puts 0 into bit 7, ROR (14) puts the old C into bit 7, and ASR (15) keeps bit 7. All three shift right, put the old bit 0 in C, set V = N xor C, and keep H.
- R9: SWAP (code 16) exchanges the two nibbles, and SER (code 17) gives 0xFF. Both write the result and change no flag.
- R10: When an operation updates N or V, S equals N xor V. Bits I and T always pass through from `flg_in`.
- R11: Synchronous active-high reset clears `flg_q` to 0. `flg_q` takes the new flag byte on the clock edge after a cycle with `issue` high, and holds in every other cycle.
- R12: Codes 20 to 31 write nothing and change no flag. `res_we` is `issue` gated by whether the operation writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Execute the operation this cycle |
| op_code | input | 5 | Operation code |
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand (register or immediate) |
| flg_in | input | 8 | Current flag byte |
| res | output | 8 | Combinational result |
| res_we | output | 1 | Write the result back |
| flg_q | output | 8 | Registered updated flag byte |

## Verification
The assertions check several rules on every cycle:
- the flag register holds while `issue` is low;
- I and T pass through, and S equals N xor V for every operation that touches N or V;
- compares and unknown codes never raise `res_we`;
- SWAP, SER and the logic group leave the flags they must not change;
- the Z chaining of SBC and CPC.

Only the bench scenarios can show the arithmetic values themselves. These include carry and half-carry at the nibble and byte boundaries, signed overflow on the 0x7F/0x80 edges, and the bits fed into shifts and rotates. The bench compares them against an independent integer model.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;

    localparam int W   = 8;
    localparam int NIB = W / 2;
    localparam int OPW = 5;
    localparam int FW  = 8;

    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_N = 2;
    localparam int FB_V = 3;
    localparam int FB_S = 4;
    localparam int FB_H = 5;
    localparam int FB_T = 6;
    localparam int FB_I = 7;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16,
        OP_SER  = 5'd17,
        OP_CP   = 5'd18,
        OP_CPC  = 5'd19
    } alu_op_e;

    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [W-1:0] val;
        logic         c;
        logic         h;
        logic         v;
    } arith_out_t;

    localparam logic [FW-1:0] MASK_FULL  = 8'b0011_1111;
    localparam logic [FW-1:0] MASK_NOH   = 8'b0001_1111;
    localparam logic [FW-1:0] MASK_ZNV   = 8'b0001_1110;
    localparam logic [FW-1:0] MASK_NONE  = 8'b0000_0000;

    function automatic logic [FW-1:0] op_mask(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_CP, OP_CPC, OP_NEG,
            OP_LSL, OP_ROL:                  return MASK_FULL;
            OP_COM, OP_LSR, OP_ROR, OP_ASR:  return MASK_NOH;
            OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC:                  return MASK_ZNV;
            default:                         return MASK_NONE;
        endcase
    endfunction

    function automatic logic writes_result(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_XOR,
            OP_COM, OP_NEG, OP_INC, OP_DEC, OP_LSL, OP_LSR, OP_ROL,
            OP_ROR, OP_ASR, OP_SWAP, OP_SER: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    function automatic logic chains_zero(input alu_op_e op);
        return (op == OP_SBC) || (op == OP_CPC);
    endfunction

endpackage

// File: rtl/byte_alu_addsub.sv
`timescale 1ns/1ps
module byte_alu_addsub
    import byte_alu_pkg::*;
(
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output arith_out_t   out
);
    logic [W:0] full;

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        end
        out.val = full[W-1:0];
        out.c   = full[W];
        // carry or borrow into bit NIB is the carry or borrow out of bit NIB-1
        out.h   = x[NIB] ^ y[NIB] ^ full[NIB];
        if (sub) begin
            out.v = (x[W-1] != y[W-1]) && (full[W-1] != x[W-1]);
        end else begin
            out.v = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
        end
    end
endmodule

// File: rtl/byte_alu_logic.sv
`timescale 1ns/1ps
module byte_alu_logic
    import byte_alu_pkg::*;
(
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] val,
    output logic         v
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        val = a;
        v   = 1'b0;
        case (op)
            OP_AND: val = a & b;
            OP_OR:  val = a | b;
            OP_XOR: val = a ^ b;
            OP_INC: begin
                val = a + ONE;
                v   = (a == MAX_POS);
            end
            OP_DEC: begin
                val = a - ONE;
                v   = (a == MIN_NEG);
            end
            OP_SER: val = '1;
            default: val = a;
        endcase
    end
endmodule

// File: rtl/byte_alu_shift.sv
`timescale 1ns/1ps
module byte_alu_shift
    import byte_alu_pkg::*;
(
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] val,
    output logic         c,
    output logic         h
);
    always_comb begin
        val = a;
        c   = a[0];
        h   = a[NIB-1];
        case (op)
            OP_LSL: begin
                val = {a[W-2:0], 1'b0};
                c   = a[W-1];
            end
            OP_ROL: begin
                val = {a[W-2:0], cin};
                c   = a[W-1];
            end
            OP_LSR: val = {1'b0, a[W-1:1]};
            OP_ROR: val = {cin, a[W-1:1]};
            OP_ASR: val = {a[W-1], a[W-1:1]};
            OP_SWAP: val = {a[NIB-1:0], a[W-1:NIB]};
            default: val = a;
        endcase
    end
endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu
    import byte_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           issue,
    input  logic [OPW-1:0] op_code,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [FW-1:0]  flg_in,
    output logic [W-1:0]   res,
    output logic           res_we,
    output logic [FW-1:0]  flg_q
);
    alu_op_e      op;
    logic [W-1:0] as_x, as_y;
    logic         as_cin, as_sub;
    arith_out_t   as_out;
    logic [W-1:0] lg_val;
    logic         lg_v;
    logic [W-1:0] sh_val;
    logic         sh_c, sh_h;

    logic [W-1:0]  res_raw;
    logic          c_new, h_new, v_new, n_new, z_new;
    flags_t        cand;
    logic [FW-1:0] mask;
    logic [FW-1:0] flg_next;

    assign op = alu_op_e'(op_code);

    // operand steering for the shared adder/subtractor
    always_comb begin
        as_x   = opa;
        as_y   = opb;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = flg_in[FB_C];
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = flg_in[FB_C];
            end
            OP_NEG: begin
                as_x   = '0;
                as_y   = opa;
                as_sub = 1'b1;
            end
            OP_COM: begin
                as_x   = '1;
                as_y   = opa;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    byte_alu_addsub u_addsub (
        .x   (as_x),
        .y   (as_y),
        .cin (as_cin),
        .sub (as_sub),
        .out (as_out)
    );

    byte_alu_logic u_logic (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .val (lg_val),
        .v   (lg_v)
    );

    byte_alu_shift u_shift (
        .op  (op),
        .a   (opa),
        .cin (flg_in[FB_C]),
        .val (sh_val),
        .c   (sh_c),
        .h   (sh_h)
    );

    // result and raw flag selection
    always_comb begin
        res_raw = opa;
        c_new   = flg_in[FB_C];
        h_new   = flg_in[FB_H];
        v_new   = flg_in[FB_V];
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                res_raw = as_out.val;
                c_new   = as_out.c;
                h_new   = as_out.h;
                v_new   = as_out.v;
            end
            OP_COM: begin
                res_raw = as_out.val;
                c_new   = 1'b1;
                v_new   = 1'b0;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_SER: begin
                res_raw = lg_val;
                v_new   = lg_v;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP: begin
                res_raw = sh_val;
                c_new   = sh_c;
                h_new   = sh_h;
                v_new   = sh_val[W-1] ^ sh_c;
            end
            default: res_raw = opa;
        endcase
    end

    // flag assembly and per-operation masking
    always_comb begin
        n_new  = res_raw[W-1];
        z_new  = (res_raw == '0) && (!chains_zero(op) || flg_in[FB_Z]);
        cand.i = flg_in[FB_I];
        cand.t = flg_in[FB_T];
        cand.h = h_new;
        cand.s = n_new ^ v_new;
        cand.v = v_new;
        cand.n = n_new;
        cand.z = z_new;
        cand.c = c_new;
        mask     = op_mask(op);
        flg_next = (cand & mask) | (flg_in & ~mask);
    end

    assign res    = res_raw;
    assign res_we = issue & writes_result(op);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else if (issue) begin
            flg_q <= flg_next;
        end
    end
endmodule

// File: rtl/byte_alu_checker.sv
`timescale 1ns/1ps
module byte_alu_checker
    import byte_alu_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           issue,
    input logic [OPW-1:0] op_code,
    input logic [FW-1:0]  flg_in,
    input logic [W-1:0]   res,
    input logic           res_we,
    input logic [FW-1:0]  flg_q
);
    logic touches_nv;
    logic logic_grp;
    logic is_cmp;
    logic chain_op;
    logic no_flag_op;
    logic unknown;

    assign touches_nv = (op_code <= 5'd15) || (op_code == 5'd18) || (op_code == 5'd19);
    assign logic_grp  = (op_code == 5'd4) || (op_code == 5'd5) || (op_code == 5'd6)
                     || (op_code == 5'd9) || (op_code == 5'd10);
    assign is_cmp     = (op_code == 5'd18) || (op_code == 5'd19);
    assign chain_op   = (op_code == 5'd3) || (op_code == 5'd19);
    assign no_flag_op = (op_code == 5'd16) || (op_code == 5'd17);
    assign unknown    = (op_code > 5'd19);

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(flg_q));

    a_r10_it_pass: assert property (@(posedge clk) disable iff (rst)
        issue |=> flg_q[7:6] == $past(flg_in[7:6]));

    a_r10_sign_rule: assert property (@(posedge clk) disable iff (rst)
        issue && touches_nv |=> flg_q[4] == (flg_q[2] ^ flg_q[3]));

    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        is_cmp |-> !res_we);

    a_r3_z_chain: assert property (@(posedge clk) disable iff (rst)
        issue && chain_op && !flg_in[1] |=> !flg_q[1]);

    a_r5_keep_c_h: assert property (@(posedge clk) disable iff (rst)
        issue && logic_grp |=> (flg_q[0] == $past(flg_in[0])) && (flg_q[5] == $past(flg_in[5])));

    a_r9_no_flags: assert property (@(posedge clk) disable iff (rst)
        issue && no_flag_op |=> flg_q == $past(flg_in));

    a_r12_no_write: assert property (@(posedge clk) disable iff (rst)
        unknown |-> !res_we);

    a_r12_no_flags: assert property (@(posedge clk) disable iff (rst)
        issue && unknown |=> flg_q == $past(flg_in));

    a_r1_zero_flag: assert property (@(posedge clk) disable iff (rst)
        issue && (op_code == 5'd0) |=> flg_q[1] == ($past(res) == 8'h00));
endmodule

bind byte_alu byte_alu_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .issue   (issue),
    .op_code (op_code),
    .flg_in  (flg_in),
    .res     (res),
    .res_we  (res_we),
    .flg_q   (flg_q)
);

// File: tb/sim_byte_alu.sv
`timescale 1ns/1ps
module sim_byte_alu;
    logic       clk = 1'b0;
    logic       rst;
    logic       issue;
    logic [4:0] op_code;
    logic [7:0] opa, opb, flg_in;
    logic [7:0] res;
    logic       res_we;
    logic [7:0] flg_q;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [7:0] exp_flg;

    always #5 clk = ~clk;

    byte_alu u0 (
        .clk(clk), .rst(rst), .issue(issue), .op_code(op_code),
        .opa(opa), .opb(opb), .flg_in(flg_in),
        .res(res), .res_we(res_we), .flg_q(flg_q)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic string req_of(input int op);
        case (op)
            0, 1:               return "R1";
            2:                  return "R2";
            3:                  return "R2/R3";
            4, 5, 6, 9, 10:     return "R5";
            7, 8:               return "R6";
            11, 13:             return "R7";
            12, 14, 15:         return "R8";
            16, 17:             return "R9";
            18, 19:             return "R4";
            default:            return "R12";
        endcase
    endfunction

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // independent integer reference model
    function automatic void model(input int op, input int a, input int b, input logic [7:0] f,
                                  output logic we, output logic [7:0] r, output logic [7:0] nf);
        int t, lo, sv, cin, rv;
        logic zr, upd;
        nf  = f;
        we  = 1'b1;
        rv  = a;
        upd = 1'b1;
        cin = f[0] ? 1 : 0;
        case (op)
            0, 1, 2, 3, 18, 19: begin
                if (op == 0 || op == 2 || op == 18) cin = 0;
                if (op <= 1) begin
                    t = a + b + cin; lo = (a % 16) + (b % 16) + cin; sv = sx(a) + sx(b) + cin;
                    nf[0] = (t > 255); nf[5] = (lo > 15);
                end else begin
                    t = a - b - cin; lo = (a % 16) - (b % 16) - cin; sv = sx(a) - sx(b) - cin;
                    nf[0] = (t < 0); nf[5] = (lo < 0);
                end
                rv = (t + 512) % 256;
                nf[3] = (sv < -128) || (sv > 127);
                we = (op < 18);
            end
            4: begin rv = a & b; nf[3] = 1'b0; end
            5: begin rv = a | b; nf[3] = 1'b0; end
            6: begin rv = a ^ b; nf[3] = 1'b0; end
            7: begin rv = 255 - a; nf[0] = 1'b1; nf[3] = 1'b0; end
            8: begin rv = (256 - a) % 256; nf[0] = (a != 0); nf[3] = (a == 128); nf[5] = ((a % 16) != 0); end
            9: begin rv = (a + 1) % 256; nf[3] = (a == 127); end
            10: begin rv = (a + 255) % 256; nf[3] = (a == 128); end
            11, 13: begin
                rv = ((a * 2) + ((op == 13) ? cin : 0)) % 256;
                nf[0] = (a >= 128); nf[5] = ((a / 8) % 2) == 1;
                nf[3] = (rv >= 128) ^ nf[0];
            end
            12, 14, 15: begin
                rv = a / 2;
                if (op == 14) rv = rv + cin * 128;
                if (op == 15) rv = rv + (a & 128);
                nf[0] = (a % 2) == 1;
                nf[3] = (rv >= 128) ^ nf[0];
            end
            16: begin rv = (a % 16) * 16 + a / 16; upd = 1'b0; end
            17: begin rv = 255; upd = 1'b0; end
            default: begin we = 1'b0; upd = 1'b0; end
        endcase
        r = rv[7:0];
        if (upd) begin
            zr = (r == 8'h00);
            if (op == 3 || op == 19) zr = zr && f[1];
            nf[1] = zr;
            nf[2] = r[7];
            nf[4] = nf[2] ^ nf[3];
        end
    endfunction

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic step(input int op, input int a, input int b, input logic [7:0] f, input logic iss);
        logic we_e;
        logic [7:0] r_e, nf_e;
        string tag;
        tag = req_of(op);
        model(op, a, b, f, we_e, r_e, nf_e);
        @(negedge clk);
        issue = iss; op_code = op[4:0]; opa = a[7:0]; opb = b[7:0]; flg_in = f;
        #1;
        check8(tag, "res_we", {7'b0, res_we}, {7'b0, we_e & iss});
        if (we_e && iss) check8(tag, "result", res, r_e);
        if (iss) exp_flg = nf_e;
        @(posedge clk);
        #1;
        check8(iss ? tag : "R11", "flags", flg_q, exp_flg);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; issue = 1'b0; op_code = '0; opa = '0; opb = '0; flg_in = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check8("R11", "reset flags", flg_q, 8'h00);
        exp_flg = 8'h00;
        @(negedge clk);
        rst = 1'b0;

        // directed corners
        step(0, 8'h0F, 8'h01, 8'h00, 1'b1);   // R1 half carry
        step(0, 8'h7F, 8'h01, 8'h00, 1'b1);   // R1 overflow
        step(1, 8'hFF, 8'h00, 8'h01, 1'b1);   // R1 carry in, zero, carry out
        step(2, 8'h10, 8'h01, 8'h00, 1'b1);   // R2 half borrow
        step(2, 8'h80, 8'h01, 8'h00, 1'b1);   // R2 overflow
        step(3, 8'h05, 8'h05, 8'h00, 1'b1);   // R3 Z stays clear
        step(3, 8'h05, 8'h05, 8'h02, 1'b1);   // R3 Z kept set
        step(19, 8'h05, 8'h04, 8'h00, 1'b1);  // R3/R4 chained compare
        step(18, 8'h03, 8'h07, 8'hC0, 1'b1);  // R4 compare borrow, no write
        step(9, 8'h7F, 8'h00, 8'h21, 1'b1);   // R5 INC overflow keeps C,H
        step(10, 8'h80, 8'h00, 8'h00, 1'b1);  // R5 DEC overflow
        step(6, 8'h5A, 8'h5A, 8'h29, 1'b1);   // R5 clear via XOR
        step(7, 8'h00, 8'h00, 8'h20, 1'b1);   // R6 COM keeps H
        step(8, 8'h80, 8'h00, 8'h00, 1'b1);   // R6 NEG of 0x80
        step(8, 8'h00, 8'h00, 8'h3F, 1'b1);   // R6 NEG of zero
        step(13, 8'h88, 8'h00, 8'h01, 1'b1);  // R7 rotate left with carry
        step(11, 8'h40, 8'h00, 8'h00, 1'b1);  // R7 shift into sign
        step(15, 8'h81, 8'h00, 8'h00, 1'b1);  // R8 arithmetic shift
        step(14, 8'h01, 8'h00, 8'h01, 1'b1);  // R8 rotate right with carry
        step(12, 8'h01, 8'h00, 8'h20, 1'b1);  // R8 logical shift keeps H
        step(16, 8'hA5, 8'h00, 8'h3F, 1'b1);  // R9 swap, no flags
        step(17, 8'h00, 8'h00, 8'h00, 1'b1);  // R9 set register
        step(21, 8'h12, 8'h34, 8'h55, 1'b1);  // R12 unknown code
        step(0, 8'hFF, 8'hFF, 8'hC0, 1'b1);   // R10 I,T pass through
        step(0, 8'h01, 8'h01, 8'hAA, 1'b0);   // R11 hold while idle

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 21), $urandom_range(0, 255), $urandom_range(0, 255),
                 8'($urandom_range(0, 255)), ($urandom_range(0, 3) != 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule